// File: doc/BRIEF.md
# Pattern Segment Playback Sequencer

This block feeds a transmit lane from a pattern memory. A program is a short table of slots. Each slot names a segment by base address and length in 32-bit words, and carries a play mode. On a start request the sequencer takes one of sixteen stored programs. It plays each valid slot in index order, issuing one memory read per clock. It then hands the returned words on as an output stream, at one word per clock, toward a serializer.

Each slot plays its segment in one of three ways: once, a programmed number of times, or without end. When the last valid slot of a program has finished, the sequencer stops and raises a completion flag. A running sequence can be redirected to another stored program. The change happens either at once or when the current pass of the segment reaches its last word. When the pattern source is a pseudo-random generator, the switch is always taken at once. A stop request halts playback without raising the completion flag.

Top module: `pattern_seq_player`

## Requirements
- R1: After reset `busy`, `done` and `outValid` are low and no memory read is issued.
- R2: While running, one read per clock is issued at addresses `base`, `base+1`, ... `base+len-1` of the current slot. A length field of 0 plays one word. The word read at the address presented in clock t appears on `outWord` with `outValid` high in clock t+2, in read order.
- R3: Mode code 0, and the spare code 3, play the segment once and then move on to the next valid slot.
- R4: Mode code 1 plays the segment as many times as the 16-bit count field says (1 to 65535). A count of 0 plays it once.
- R5: Mode code 2 repeats the segment until a stop or a switch takes effect.
- R6: Slots with the valid bit clear are skipped. After the last valid slot finishes, `busy` falls and `done` rises together in the clock after its last read.
- R7: `start` while idle selects program `startProg` (0 to 15), clears `done` and begins at its lowest valid slot. A program with no valid slot sets `done` at once and issues no read.
- R8: `stop` while running makes the read in that clock the last one. `busy` falls and `done` stays low.
- R9: `swReq` with `swImmediate` high makes the read in the request clock the last one from the old program. The next clock reads word 0 of the lowest valid slot of `swProg`.
- R10: `swReq` with `swImmediate` low lets the current pass of the segment run to its last word. The next clock starts the new program. If the new program has no valid slot, playback ends with `done`.
- R11: While `prbsSrc` is high, every switch request is taken immediately, whatever `swImmediate` says.
- R12: `swReq` while idle has no effect: no read, `busy` stays low, `done` is unchanged, and a later start plays only the program it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write one slot entry |
| cfgProg | input | 4 | Program index to write |
| cfgSlot | input | 2 | Slot index to write |
| cfgValid | input | 1 | Slot takes part in playback |
| cfgMode | input | 2 | Play mode: 0 once, 1 counted, 2 endless, 3 once |
| cfgBase | input | 16 | Segment start word address |
| cfgLen | input | 12 | Segment length in words (0 means 1) |
| cfgCount | input | 16 | Pass count for counted mode (0 means 1) |
| start | input | 1 | Begin playback of `startProg` when idle |
| stop | input | 1 | Halt playback |
| startProg | input | 4 | Program chosen by `start` |
| swReq | input | 1 | Request a switch to `swProg` |
| swImmediate | input | 1 | 1: switch now, 0: switch at end of pass |
| swProg | input | 4 | Target program of a switch |
| prbsSrc | input | 1 | Source is pseudo-random; forces immediate switching |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | 16 | Memory word address |
| memData | input | 32 | Memory word, valid the clock after the address |
| outValid | output | 1 | `outWord` carries a pattern word |
| outWord | output | 32 | Pattern word toward the serializer |
| busy | output | 1 | Playback running |
| done | output | 1 | Last valid slot finished |

## Verification
Checks on every clock cover several invariants. While running, the word offset stays inside the segment, and addresses step by one within a pass. The active slot is always a valid one, and the pass counter never reaches the programmed count. An endless slot keeps running unless stopped or switched. `done` never coexists with `busy`, and a stop ends playback on the next clock. Idle switch requests leave nothing pending. The bench scenarios alone can show the exact word order across slots, counted passes and a zero count. They also show the clock in which immediate, deferred and forced-immediate switches cut over, and the handling of an empty program.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = 16;

  typedef enum logic [1:0] {
    MODE_ONCE     = 2'd0,
    MODE_COUNT    = 2'd1,
    MODE_LOOP     = 2'd2,
    MODE_ONCE_ALT = 2'd3
  } play_mode_e;

  typedef struct packed {
    logic              valid;
    play_mode_e        mode;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
    logic [CNT_W-1:0]  count;
  } slot_cfg_t;

  typedef struct packed {
    logic issue;
    logic clear;
  } ctrl_strb_t;
endpackage

// File: rtl/seq_slot_table.sv
module seq_slot_table import seq_pkg::*; #(
  parameter int NUM_PROGS = 16,
  parameter int NUM_SLOTS = 4,
  parameter int PROG_W    = $clog2(NUM_PROGS),
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [PROG_W-1:0]    wrProg,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  slot_cfg_t            wrData,
  input  logic [PROG_W-1:0]    curProg,
  input  logic [SLOT_W-1:0]    curSlot,
  input  logic [PROG_W-1:0]    candProg,
  output logic [NUM_SLOTS-1:0] curValid,
  output logic [NUM_SLOTS-1:0] candValid,
  output slot_cfg_t            curEntry
);
  slot_cfg_t tbl [NUM_PROGS][NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PROGS; p++)
        for (int s = 0; s < NUM_SLOTS; s++)
          tbl[p][s] <= '0;
    end else if (wrEn) begin
      tbl[wrProg][wrSlot] <= wrData;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_validVec
    assign curValid[s]  = tbl[curProg][s].valid;
    assign candValid[s] = tbl[candProg][s].valid;
  end

  assign curEntry = tbl[curProg][curSlot];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl import seq_pkg::*; #(
  parameter int NUM_PROGS = 16,
  parameter int NUM_SLOTS = 4,
  parameter int PROG_W    = $clog2(NUM_PROGS),
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 stop,
  input  logic [PROG_W-1:0]    startProg,
  input  logic                 swReq,
  input  logic                 swImmediate,
  input  logic [PROG_W-1:0]    swProg,
  input  logic                 prbsSrc,
  input  logic                 segLast,
  input  logic [NUM_SLOTS-1:0] curValid,
  input  logic [NUM_SLOTS-1:0] candValid,
  input  logic                 curLive,
  input  play_mode_e           curMode,
  input  logic [CNT_W-1:0]     curCount,
  output logic [PROG_W-1:0]    curProg,
  output logic [SLOT_W-1:0]    curSlot,
  output logic [PROG_W-1:0]    candProg,
  output ctrl_strb_t           strb,
  output logic                 busy,
  output logic                 done
);
  logic              runQ, runN;
  logic              doneQ, doneN;
  logic              pendQ, pendN;
  logic [PROG_W-1:0] progQ, progN, pendProgQ, pendProgN;
  logic [SLOT_W-1:0] slotQ, slotN;
  logic [CNT_W-1:0]  passQ, passN;

  logic              immSw, candHit, nextHit, lastPass, clearSeg;
  logic [SLOT_W-1:0] candIdx, nextIdx;
  logic [CNT_W:0]    effCnt;

  // lowest valid slot of the candidate program
  always_comb begin
    candHit = 1'b0;
    candIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (candValid[i]) begin
        candHit = 1'b1;
        candIdx = SLOT_W'(i);
      end
    end
  end

  // lowest valid slot above the current one
  always_comb begin
    nextHit = 1'b0;
    nextIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (curValid[i] && (i > int'(slotQ))) begin
        nextHit = 1'b1;
        nextIdx = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    effCnt = (curCount == '0) ? (CNT_W+1)'(1) : {1'b0, curCount};
    unique case (curMode)
      MODE_COUNT: lastPass = (({1'b0, passQ} + (CNT_W+1)'(1)) >= effCnt);
      MODE_LOOP:  lastPass = 1'b0;
      default:    lastPass = 1'b1;
    endcase
  end

  assign immSw    = runQ && swReq && (swImmediate || prbsSrc) && !stop;
  assign candProg = !runQ ? startProg : (immSw ? swProg : pendProgQ);

  always_comb begin
    runN      = runQ;
    doneN     = doneQ;
    pendN     = pendQ;
    progN     = progQ;
    pendProgN = pendProgQ;
    slotN     = slotQ;
    passN     = passQ;
    clearSeg  = 1'b0;

    if (!runQ) begin
      clearSeg = 1'b1;
      pendN    = 1'b0;
      if (start) begin
        if (candHit) begin
          runN  = 1'b1;
          progN = startProg;
          slotN = candIdx;
          passN = '0;
          doneN = 1'b0;
        end else begin
          doneN = 1'b1;
        end
      end
    end else if (stop) begin
      runN     = 1'b0;
      pendN    = 1'b0;
      clearSeg = 1'b1;
    end else if (immSw) begin
      pendN    = 1'b0;
      clearSeg = 1'b1;
      if (candHit) begin
        progN = swProg;
        slotN = candIdx;
        passN = '0;
      end else begin
        runN  = 1'b0;
        doneN = 1'b1;
      end
    end else begin
      if (swReq) begin
        pendN     = 1'b1;
        pendProgN = swProg;
      end
      if (segLast) begin
        clearSeg = 1'b1;
        if (pendQ) begin
          pendN = swReq;
          if (candHit) begin
            progN = pendProgQ;
            slotN = candIdx;
            passN = '0;
          end else begin
            runN  = 1'b0;
            doneN = 1'b1;
            pendN = 1'b0;
          end
        end else if (!lastPass) begin
          passN = passQ + CNT_W'(1);
        end else if (nextHit) begin
          slotN = nextIdx;
          passN = '0;
        end else begin
          runN  = 1'b0;
          doneN = 1'b1;
          pendN = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      doneQ     <= 1'b0;
      pendQ     <= 1'b0;
      progQ     <= '0;
      pendProgQ <= '0;
      slotQ     <= '0;
      passQ     <= '0;
    end else begin
      runQ      <= runN;
      doneQ     <= doneN;
      pendQ     <= pendN;
      progQ     <= progN;
      pendProgQ <= pendProgN;
      slotQ     <= slotN;
      passQ     <= passN;
    end
  end

  assign curProg    = progQ;
  assign curSlot    = slotQ;
  assign strb.issue = runQ;
  assign strb.clear = clearSeg;
  assign busy       = runQ;
  assign done       = doneQ;

  // R6: completion is only flagged once playback has ended
  p_done_when_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !runQ);

  // R6: the slot being played always has its valid bit set
  p_active_slot_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> curLive);

  // R4: the pass counter stays below the programmed pass count
  p_pass_in_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && curMode == MODE_COUNT) |-> ({1'b0, passQ} < effCnt));

  // R5: an endless slot keeps running without a stop or switch
  p_endless_runs_r5: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && curMode == MODE_LOOP && !stop && !swReq) |=> runQ);

  // R8: stop ends playback on the next clock
  p_stop_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && stop) |=> !runQ);

  // R12: nothing is held pending while idle
  p_idle_switch_dropped_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !start) |=> (!runQ && !pendQ));
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath import seq_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strb_t        strb,
  input  logic [ADDR_W-1:0] curBase,
  input  logic [LEN_W-1:0]  curLen,
  input  logic [WORD_W-1:0] memData,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              segLast
);
  logic [LEN_W-1:0]  offsetQ;
  logic [LEN_W-1:0]  effLen;
  logic              rdDlyQ;
  logic              outValidQ;
  logic [WORD_W-1:0] outWordQ;

  assign effLen  = (curLen == '0) ? LEN_W'(1) : curLen;
  assign segLast = strb.issue && (offsetQ == effLen - LEN_W'(1));
  assign memRd   = strb.issue;
  assign memAddr = curBase + ADDR_W'(offsetQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ   <= '0;
      rdDlyQ    <= 1'b0;
      outValidQ <= 1'b0;
      outWordQ  <= '0;
    end else begin
      if (strb.clear)      offsetQ <= '0;
      else if (strb.issue) offsetQ <= offsetQ + LEN_W'(1);
      rdDlyQ    <= strb.issue;
      outValidQ <= rdDlyQ;
      if (rdDlyQ) outWordQ <= memData;
    end
  end

  assign outValid = outValidQ;
  assign outWord  = outWordQ;

  // R2: the word offset never leaves the current segment
  p_offset_in_segment_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (offsetQ < effLen));

  // R2: inside a pass the read address moves up by one word per clock
  p_addr_steps_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && $past(strb.issue) && !$past(strb.clear))
      |-> (memAddr == $past(memAddr) + ADDR_W'(1)));
endmodule

// File: rtl/pattern_seq_player.sv
module pattern_seq_player import seq_pkg::*; #(
  parameter int NUM_PROGS = 16,
  parameter int NUM_SLOTS = 4,
  parameter int WORD_W    = 32,
  parameter int PROG_W    = $clog2(NUM_PROGS),
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [PROG_W-1:0] cfgProg,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic              cfgValid,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              start,
  input  logic              stop,
  input  logic [PROG_W-1:0] startProg,
  input  logic              swReq,
  input  logic              swImmediate,
  input  logic [PROG_W-1:0] swProg,
  input  logic              prbsSrc,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memData,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              busy,
  output logic              done
);
  slot_cfg_t            wrData, curEntry;
  logic [NUM_SLOTS-1:0] curValid, candValid;
  logic [PROG_W-1:0]    curProg, candProg;
  logic [SLOT_W-1:0]    curSlot;
  ctrl_strb_t           strb;
  logic                 segLast;

  assign wrData = '{valid: cfgValid, mode: play_mode_e'(cfgMode), base: cfgBase,
                    len: cfgLen, count: cfgCount};

  seq_slot_table #(.NUM_PROGS(NUM_PROGS), .NUM_SLOTS(NUM_SLOTS),
                   .PROG_W(PROG_W), .SLOT_W(SLOT_W)) table_i (
    .clk(clk), .rstN(rstN), .wrEn(cfgWe), .wrProg(cfgProg), .wrSlot(cfgSlot),
    .wrData(wrData), .curProg(curProg), .curSlot(curSlot), .candProg(candProg),
    .curValid(curValid), .candValid(candValid), .curEntry(curEntry)
  );

  seq_ctrl #(.NUM_PROGS(NUM_PROGS), .NUM_SLOTS(NUM_SLOTS),
             .PROG_W(PROG_W), .SLOT_W(SLOT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .startProg(startProg),
    .swReq(swReq), .swImmediate(swImmediate), .swProg(swProg), .prbsSrc(prbsSrc),
    .segLast(segLast), .curValid(curValid), .candValid(candValid),
    .curLive(curEntry.valid), .curMode(curEntry.mode), .curCount(curEntry.count),
    .curProg(curProg), .curSlot(curSlot), .candProg(candProg), .strb(strb),
    .busy(busy), .done(done)
  );

  seq_datapath #(.WORD_W(WORD_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .curBase(curEntry.base),
    .curLen(curEntry.len), .memData(memData), .memRd(memRd), .memAddr(memAddr),
    .outValid(outValid), .outWord(outWord), .segLast(segLast)
  );
endmodule

// File: tb/pattern_seq_player_tb_top.sv
module pattern_seq_player_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgProg = '0;
  logic [1:0]  cfgSlot = '0;
  logic        cfgValid = 1'b0;
  logic [1:0]  cfgMode = '0;
  logic [15:0] cfgBase = '0;
  logic [11:0] cfgLen = '0;
  logic [15:0] cfgCount = '0;
  logic        start = 1'b0, stop = 1'b0;
  logic [3:0]  startProg = '0;
  logic        swReq = 1'b0, swImmediate = 1'b0, prbsSrc = 1'b0;
  logic [3:0]  swProg = '0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [31:0] memData = '0;
  logic        outValid;
  logic [31:0] outWord;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string curTag = "R1";
  logic [15:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_seq_player dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgProg(cfgProg), .cfgSlot(cfgSlot),
    .cfgValid(cfgValid), .cfgMode(cfgMode), .cfgBase(cfgBase), .cfgLen(cfgLen),
    .cfgCount(cfgCount), .start(start), .stop(stop), .startProg(startProg),
    .swReq(swReq), .swImmediate(swImmediate), .swProg(swProg), .prbsSrc(prbsSrc),
    .memRd(memRd), .memAddr(memAddr), .memData(memData), .outValid(outValid),
    .outWord(outWord), .busy(busy), .done(done)
  );

  function automatic logic [31:0] memFn(logic [15:0] a);
    return {8'h5A, 8'h00, a} ^ {a, 16'h0000};
  endfunction

  // pattern memory with one clock of read latency
  always @(posedge clk) memData <= memFn(memAddr);

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, curTag, "unexpected output word", outWord, 0);
      end else begin
        automatic logic [15:0] a = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(outWord == memFn(a), t, "output word", outWord, memFn(a));
      end
    end
  end

  task automatic pushSeg(logic [15:0] base, int len, int passes, string tag);
    for (int p = 0; p < passes; p++)
      for (int i = 0; i < ((len == 0) ? 1 : len); i++) begin
        expQ.push_back(base + 16'(i));
        tagQ.push_back(tag);
      end
  endtask

  task automatic pushProg0();
    pushSeg(16'h0100, 4, 1, "R3");
    pushSeg(16'h0200, 3, 3, "R4");
    pushSeg(16'h0300, 2, 1, "R4");
  endtask

  task automatic writeSlot(int p, int s, bit v, int m, int base, int len, int cnt);
    cfgProg = 4'(p); cfgSlot = 2'(s); cfgValid = v; cfgMode = 2'(m);
    cfgBase = 16'(base); cfgLen = 12'(len); cfgCount = 16'(cnt);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // leaves the caller in the clock of read index 0
  task automatic startProgram(int p);
    start = 1'b1; startProg = 4'(p);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulseSwitch(int p, bit imm);
    swReq = 1'b1; swProg = 4'(p); swImmediate = imm;
    @(negedge clk);
    swReq = 1'b0;
  endtask

  task automatic waitIdle(string tag);
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, tag, "expected words left", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(outValid == 1'b0 && memRd == 1'b0, "R1", "activity after reset",
          {outValid, memRd}, 0);

    // program 0: once, invalid, counted x3, counted with zero count
    writeSlot(0, 0, 1, 0, 'h100, 4, 0);
    writeSlot(0, 1, 0, 1, 'h700, 4, 2);
    writeSlot(0, 2, 1, 1, 'h200, 3, 3);
    writeSlot(0, 3, 1, 1, 'h300, 2, 0);
    // program 2: spare code with zero length, then a one-word once slot
    writeSlot(2, 0, 1, 3, 'h500, 0, 0);
    writeSlot(2, 3, 1, 0, 'h600, 1, 0);
    // program 5: endless slot in position 1
    writeSlot(5, 1, 1, 2, 'h400, 5, 0);

    // R3 R4 R6: full program 0
    curTag = "R6";
    pushProg0();
    startProgram(0);
    waitIdle("R6");
    check(done == 1'b1, "R6", "done after last slot", done, 1);
    check(busy == 1'b0, "R6", "busy after last slot", busy, 0);

    // R2 R7: another program, zero length and spare mode code
    curTag = "R7";
    pushSeg(16'h0500, 0, 1, "R2");
    pushSeg(16'h0600, 1, 1, "R7");
    startProgram(2);
    check(done == 1'b0, "R7", "done cleared by start", done, 0);
    waitIdle("R7");
    check(done == 1'b1, "R7", "done after program 2", done, 1);

    // R5 R8: endless slot halted by stop in read index 11
    curTag = "R8";
    for (int i = 0; i < 12; i++) begin
      expQ.push_back(16'h0400 + 16'(i % 5));
      tagQ.push_back("R5");
    end
    startProgram(5);
    repeat (11) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(busy == 1'b0, "R8", "busy after stop", busy, 0);
    waitIdle("R8");
    check(done == 1'b0, "R8", "done after stop", done, 0);

    // R9: immediate switch in read index 6
    curTag = "R9";
    for (int i = 0; i < 7; i++) begin
      expQ.push_back(16'h0400 + 16'(i % 5));
      tagQ.push_back("R9");
    end
    pushProg0();
    startProgram(5);
    repeat (6) @(negedge clk);
    pulseSwitch(0, 1'b1);
    waitIdle("R9");
    check(done == 1'b1, "R9", "done after switched program", done, 1);

    // R10: deferred switch in read index 2 waits for the pass end
    curTag = "R10";
    pushSeg(16'h0400, 5, 1, "R10");
    pushProg0();
    startProgram(5);
    repeat (2) @(negedge clk);
    pulseSwitch(0, 1'b0);
    waitIdle("R10");
    check(done == 1'b1, "R10", "done after deferred switch", done, 1);

    // R11: pseudo-random source forces the switch to be immediate
    curTag = "R11";
    pushSeg(16'h0400, 3, 1, "R11");
    pushProg0();
    prbsSrc = 1'b1;
    startProgram(5);
    repeat (2) @(negedge clk);
    pulseSwitch(0, 1'b0);
    waitIdle("R11");
    prbsSrc = 1'b0;

    // R7: program without valid slots
    curTag = "R7";
    startProgram(9);
    check(done == 1'b1, "R7", "done for empty program", done, 1);
    check(busy == 1'b0, "R7", "busy for empty program", busy, 0);
    waitIdle("R7");

    // R12: switch request while idle is dropped
    curTag = "R12";
    pulseSwitch(0, 1'b1);
    pulseSwitch(0, 1'b0);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R12", "busy after idle switch", busy, 0);
    check(done == 1'b1, "R12", "done after idle switch", done, 1);
    pushSeg(16'h0500, 0, 1, "R12");
    pushSeg(16'h0600, 1, 1, "R12");
    startProgram(2);
    waitIdle("R12");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired: actual busy %0d expected 0", busy);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule